// File: doc/BRIEF.md
# Pipelined Store Cache Write Unit

This block is the load/store path of a small direct-mapped data cache. A store is handled in two pipeline stages. The first checks the tag. The second writes the data array one cycle later from a one-entry delayed-write register. This lets the tag check of a new store run in the same cycle as the array write of the store before it. Only stores that have passed their tag check enter the delayed-write register. A load that reads the word held there gets the register's data through a bypass path.

A miss on a load or a store starts a refill from an internal backing array with a fixed latency. While the refill runs, the block raises a stall toward the requester and ignores any new request. The backing array is kept current by write-through: each store also writes the backing word when it leaves the delayed-write register. When the refill completes, the missed request finishes inside the block. A missed load returns the filled word. A missed store enters the delayed-write register only after the line has been filled.

Top module: `store_pipe_cache`

## Requirements
- R1: After reset, `stall` and `rsp_valid` are low and every line is invalid, so the first access to any address misses.
- R2: The cache is direct mapped. The line index is `req_addr[3:0]` and the tag is `req_addr[7:4]`. A repeat access to a filled address hits. An access with the same index and a different tag misses and replaces the line.
- R3: A request accepted (`req_valid` high while `stall` is low) that hits produces `rsp_valid` with `rsp_hit`=1 in the next cycle. For a load, `rsp_rdata` holds the word.
- R4: After a miss is accepted, `stall` is high for exactly 4 cycles, starting in the cycle after acceptance. In the first cycle with `stall` low again, `rsp_valid`=1 and `rsp_hit`=0. For a load, `rsp_rdata` is the backing word. The backing word at address a initially holds {8'hC0, a, ~a, a}.
- R5: A store hit responds in the next cycle with `rsp_hit`=1 and `rsp_rdata`=0. A later load of that address returns the stored data.
- R6: A load accepted in the cycle directly after a store to the same word returns the store's data (bypass from the delayed-write register).
- R7: A store that misses is written only after its refill. Its response has `rsp_hit`=0 and `rsp_rdata`=0, and a later load of the address hits with the stored data.
- R8: Requests presented while `stall` is high are ignored. They produce no response and change no cache or backing content.
- R9: Stores write through to the backing array, so a stored word is returned after its line has been evicted and refilled.
- R10: Only stores enter the delayed-write register, and it is empty while `stall` is high. A load that does not match the pending word reads the array, which already holds every older store.
- R11: Back-to-back stores to the same word take effect in order, so the last one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 8 | Word address |
| req_wdata | input | 32 | Store data |
| stall | output | 1 | Refill in progress; requests are not taken |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_hit | output | 1 | 1 = request hit, 0 = it was served by a refill |
| rsp_rdata | output | 32 | Load data (zero for stores) |

## Verification
A hit's response is registered once, so the bench samples it at the falling edge just after the rising edge that accepted the request. A miss's response comes four cycles later. The bench counts stall cycles at each falling edge until the response shows, and it compares that count with 4. The bypass, ordering and non-matching cases drive requests on consecutive falling edges, so the load meets the pending store before it retires, and each response is read at the falling edge following its own accepting edge. For the ignored-request case, the bench drives a store throughout a refill. It then confirms that only the refill's response appeared and that the target word still holds its initial backing value.

// File: rtl/swc_pkg.sv
// Shared types and helpers for the pipelined store cache.
// Assumes word addresses of at most 8 significant bits for the seed pattern.
package swc_pkg;

    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_BUSY = 1'b1
    } fill_state_t;

    // Initial content of a backing word: {C0, a, ~a, a}.
    function automatic logic [31:0] seed_word(input logic [7:0] a);
        return {8'hC0, a, ~a, a};
    endfunction

endpackage

// File: rtl/swc_tag_store.sv
// Tag and valid bits of a direct-mapped cache.
// Lookup is combinational; a refill sets the tag and marks the line valid.
// Assumes tags of invalid lines are never trusted (valid gates the compare).
module swc_tag_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] line_valid;
    logic [TAG_W-1:0] line_tag [LINES];

    // Valid bits: cleared by reset, set by a refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_valid <= '0;
        end else if (fill_we) begin
            line_valid[fill_idx] <= 1'b1;
        end
    end

    // Tag storage: written on refill only.
    always_ff @(posedge clk) begin
        if (fill_we) begin
            line_tag[fill_idx] <= fill_tag;
        end
    end

    // Hit when the indexed line is valid and its tag matches.
    always_comb begin
        lk_hit = line_valid[lk_idx] && (line_tag[lk_idx] == lk_tag);
    end

endmodule

// File: rtl/swc_data_array.sv
// Single write port data array, one word per line, combinational read.
// Assumes the caller arbitrates the write port between refill and retiring store.
module swc_data_array #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    logic [DATA_W-1:0] words [LINES];

    // Array write from the single port.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[wr_idx] <= wr_data;
        end
    end

    // Read in the tag stage.
    always_comb begin
        rd_data = words[rd_idx];
    end

endmodule

// File: rtl/swc_delayed_write.sv
// One-entry delayed-write register for stores that passed their tag check.
// It retires into the array on the next cycle the write port is free, and
// forwards its data to a load of the same word.
// Assumes capture never coincides with a blocked retire of a valid entry.
module swc_delayed_write #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              port_free,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              pend_valid,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [DATA_W-1:0] pend_data,
    output logic              retire,
    output logic              fwd_hit
);
    // Retire whenever an entry is held and the port is free.
    always_comb begin
        retire  = pend_valid && port_free;
        fwd_hit = pend_valid && (pend_addr == look_addr);
    end

    // Entry register: capture a new store, otherwise empty on retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_data  <= '0;
        end else if (cap_en) begin
            pend_valid <= 1'b1;
            pend_addr  <= cap_addr;
            pend_data  <= cap_data;
        end else if (retire) begin
            pend_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/swc_refill.sv
// Miss handler: holds the missed request, waits a fixed latency, then
// delivers the backing word. Owns the backing array, which stores write
// through to.
// Assumes REFILL_CYCLES >= 2 so the delayed-write entry drains first.
module swc_refill
    import swc_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 32,
    parameter int REFILL_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              st_write,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              wt_en,
    input  logic [ADDR_W-1:0] wt_addr,
    input  logic [DATA_W-1:0] wt_data,
    output logic              busy,
    output logic              done,
    output logic              m_write,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_data,
    output logic [DATA_W-1:0] fill_data
);
    localparam int WORDS = 1 << ADDR_W;
    localparam int CNT_W = (REFILL_CYCLES > 2) ? $clog2(REFILL_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REFILL_CYCLES - 1);

    fill_state_t       state;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] backing [WORDS];

    always_comb begin
        busy      = (state == FILL_BUSY);
        done      = busy && (cnt == LAST);
        fill_data = backing[m_addr];
    end

    // Refill sequencer: idle until a miss, then count the latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FILL_IDLE;
            cnt   <= '0;
        end else if (state == FILL_IDLE) begin
            if (start) begin
                state <= FILL_BUSY;
                cnt   <= '0;
            end
        end else if (done) begin
            state <= FILL_IDLE;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Missed request holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_write <= 1'b0;
            m_addr  <= '0;
            m_data  <= '0;
        end else if (start && !busy) begin
            m_write <= st_write;
            m_addr  <= st_addr;
            m_data  <= st_data;
        end
    end

    // Backing array: seeded on reset, written through by retiring stores.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                backing[i] <= DATA_W'(seed_word(8'(i)));
            end
        end else if (wt_en) begin
            backing[wt_addr] <= wt_data;
        end
    end

endmodule

// File: rtl/store_pipe_cache.sv
// Direct-mapped cache with stores split into tag-check and delayed-write
// stages. Loads read the array in the tag stage and bypass from the pending
// store. Misses stall the requester while a fixed-latency refill runs.
// Assumes the requester holds nothing: a stalled request is simply dropped.
module store_pipe_cache #(
    parameter int ADDR_W        = 8,
    parameter int IDX_W         = 4,
    parameter int DATA_W        = 32,
    parameter int REFILL_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              stall,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic              accept, lk_hit, hit_acc, miss_start;
    logic              fill_busy, fill_done, m_write;
    logic [ADDR_W-1:0] m_addr;
    logic [DATA_W-1:0] m_data, fill_data, arr_rdata;
    logic              pend_valid, retire, fwd_hit, cap_en;
    logic [ADDR_W-1:0] pend_addr, cap_addr;
    logic [DATA_W-1:0] pend_data, cap_data;
    logic              arr_we;
    logic [IDX_W-1:0]  arr_widx;
    logic [DATA_W-1:0] arr_wdata;

    // Request acceptance and tag-stage outcome.
    always_comb begin
        stall      = fill_busy;
        accept     = req_valid && !fill_busy;
        hit_acc    = accept && lk_hit;
        miss_start = accept && !lk_hit;
    end

    // Delayed-write capture: a store hit now, or a missed store after refill.
    always_comb begin
        cap_en   = (hit_acc && req_write) || (fill_done && m_write);
        cap_addr = fill_done ? m_addr : req_addr;
        cap_data = fill_done ? m_data : req_wdata;
    end

    // Write port arbitration: refill first, then the retiring store.
    always_comb begin
        arr_we    = fill_done || pend_valid;
        arr_widx  = fill_done ? m_addr[IDX_W-1:0] : pend_addr[IDX_W-1:0];
        arr_wdata = fill_done ? fill_data : pend_data;
    end

    swc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (req_addr[IDX_W-1:0]),
        .lk_tag   (req_addr[ADDR_W-1:IDX_W]),
        .lk_hit   (lk_hit),
        .fill_we  (fill_done),
        .fill_idx (m_addr[IDX_W-1:0]),
        .fill_tag (m_addr[ADDR_W-1:IDX_W])
    );

    swc_data_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rd_idx  (req_addr[IDX_W-1:0]),
        .rd_data (arr_rdata),
        .wr_en   (arr_we),
        .wr_idx  (arr_widx),
        .wr_data (arr_wdata)
    );

    swc_delayed_write #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (cap_en),
        .cap_addr   (cap_addr),
        .cap_data   (cap_data),
        .port_free  (!fill_done),
        .look_addr  (req_addr),
        .pend_valid (pend_valid),
        .pend_addr  (pend_addr),
        .pend_data  (pend_data),
        .retire     (retire),
        .fwd_hit    (fwd_hit)
    );

    swc_refill #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REFILL_CYCLES(REFILL_CYCLES)
    ) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (miss_start),
        .st_write  (req_write),
        .st_addr   (req_addr),
        .st_data   (req_wdata),
        .wt_en     (retire),
        .wt_addr   (pend_addr),
        .wt_data   (pend_data),
        .busy      (fill_busy),
        .done      (fill_done),
        .m_write   (m_write),
        .m_addr    (m_addr),
        .m_data    (m_data),
        .fill_data (fill_data)
    );

    // Response register: hits one cycle after accept, misses at refill end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= hit_acc || fill_done;
            rsp_hit   <= hit_acc;
            if (hit_acc && !req_write) begin
                rsp_rdata <= fwd_hit ? pend_data : arr_rdata;
            end else if (fill_done && !m_write) begin
                rsp_rdata <= fill_data;
            end else begin
                rsp_rdata <= '0;
            end
        end
    end

endmodule

// File: rtl/store_pipe_cache_chk.sv
// Property checker for store_pipe_cache, attached with bind.
// Assumes the pending-entry flag of the top module is visible as pend_valid.
module store_pipe_cache_chk #(
    parameter int REFILL_CYCLES = 4
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic stall,
    input logic rsp_valid,
    input logic rsp_hit,
    input logic pend_valid
);
    logic [7:0] stall_run;

    // Count consecutive stall cycles seen before the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_run <= '0;
        end else begin
            stall_run <= stall ? stall_run + 8'd1 : 8'd0;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!stall && !rsp_valid));

    // R8
    no_rsp_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !rsp_valid);

    // R4
    stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (stall_run < 8'(REFILL_CYCLES)));

    // R4
    miss_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> (rsp_valid && !rsp_hit && stall_run == 8'(REFILL_CYCLES)));

    // R3
    hit_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> $past(req_valid && !stall));

    // R10
    pend_empty_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !pend_valid);

endmodule

bind store_pipe_cache store_pipe_cache_chk #(.REFILL_CYCLES(REFILL_CYCLES)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .stall      (stall),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .pend_valid (pend_valid)
);

// File: tb/test_store_pipe_cache.sv
// Directed bench for store_pipe_cache: one task per scenario.
module test_store_pipe_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        stall, rsp_valid, rsp_hit;
    logic [31:0] rsp_rdata;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    store_pipe_cache i_store_pipe_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .stall(stall),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata)
    );

    function automatic logic [31:0] seed(input logic [7:0] a);
        return {8'hC0, a, ~a, a};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [7:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    endtask

    // One request with an idle cycle before it; waits for its response.
    task automatic issue(input logic w, input logic [7:0] a, input logic [31:0] d,
                         output logic hit, output logic [31:0] q, output int stalls);
        @(negedge clk);
        drive(w, a, d);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        stalls = 0;
        while (!rsp_valid && stalls < 20) begin
            if (stall) stalls++;
            @(negedge clk);
        end
        hit = rsp_hit; q = rsp_rdata;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(stall == 1'b0, "R1 stall after reset", 32'(stall), 0);
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 0);
    endtask

    task automatic t_miss_then_hit();
        logic h; logic [31:0] q; int s;
        issue(1'b0, 8'h23, 0, h, q, s);
        chk(h == 1'b0, "R1 first access misses", 32'(h), 0);
        chk(s == 4, "R4 stall cycles", 32'(s), 4);
        chk(q == seed(8'h23), "R4 fill data", q, seed(8'h23));
        issue(1'b0, 8'h23, 0, h, q, s);
        chk(h == 1'b1 && s == 0, "R2 R3 repeat load hits", 32'(h), 1);
        chk(q == seed(8'h23), "R3 hit data", q, seed(8'h23));
    endtask

    task automatic t_store_hit();
        logic h; logic [31:0] q; int s;
        issue(1'b1, 8'h23, 32'h1111_2222, h, q, s);
        chk(h == 1'b1 && q == 0, "R5 store hit response", q, 0);
        issue(1'b0, 8'h23, 0, h, q, s);
        chk(h == 1'b1 && q == 32'h1111_2222, "R5 load after store", q, 32'h1111_2222);
    endtask

    task automatic t_bypass();
        @(negedge clk); drive(1'b1, 8'h23, 32'hAAAA_5555);
        @(negedge clk);
        chk(rsp_valid && rsp_hit, "R6 store response", 32'(rsp_hit), 1);
        drive(1'b0, 8'h23, 0);
        @(negedge clk); req_valid = 1'b0;
        chk(rsp_valid && rsp_hit && rsp_rdata == 32'hAAAA_5555, "R6 bypass load",
            rsp_rdata, 32'hAAAA_5555);
    endtask

    task automatic t_order();
        @(negedge clk); drive(1'b1, 8'h23, 32'h0000_0001);
        @(negedge clk); drive(1'b1, 8'h23, 32'h0000_0002);
        @(negedge clk); drive(1'b0, 8'h23, 0);
        @(negedge clk); req_valid = 1'b0;
        chk(rsp_valid && rsp_rdata == 32'h2, "R11 last store wins", rsp_rdata, 32'h2);
    endtask

    task automatic t_nonmatch();
        logic h; logic [31:0] q; int s;
        issue(1'b0, 8'h24, 0, h, q, s);
        chk(h == 1'b0 && q == seed(8'h24), "R4 second line fill", q, seed(8'h24));
        @(negedge clk); drive(1'b1, 8'h23, 32'h0000_0033);
        @(negedge clk); drive(1'b1, 8'h24, 32'h0000_0044);
        @(negedge clk); drive(1'b0, 8'h23, 0);
        @(negedge clk); req_valid = 1'b0;
        chk(rsp_valid && rsp_hit && rsp_rdata == 32'h33, "R10 array read past pending",
            rsp_rdata, 32'h33);
        issue(1'b0, 8'h24, 0, h, q, s);
        chk(q == 32'h44, "R10 pending retired", q, 32'h44);
    endtask

    task automatic t_store_miss();
        logic h; logic [31:0] q; int s;
        issue(1'b1, 8'h57, 32'h0000_5757, h, q, s);
        chk(h == 1'b0 && s == 4 && q == 0, "R7 store miss response", q, 0);
        issue(1'b0, 8'h57, 0, h, q, s);
        chk(h == 1'b1 && q == 32'h5757, "R7 load after store miss", q, 32'h5757);
    endtask

    task automatic t_conflict();
        logic h; logic [31:0] q; int s;
        issue(1'b0, 8'h67, 0, h, q, s);
        chk(h == 1'b0 && q == seed(8'h67), "R2 same index other tag misses", q, seed(8'h67));
        issue(1'b0, 8'h57, 0, h, q, s);
        chk(h == 1'b0, "R2 evicted line misses", 32'(h), 0);
        chk(q == 32'h5757, "R9 write-through survives eviction", q, 32'h5757);
    endtask

    task automatic t_ignore();
        int s = 0; int extra = 0;
        @(negedge clk); drive(1'b0, 8'h80, 0);
        @(negedge clk);
        drive(1'b1, 8'h90, 32'hDEAD_BEEF);
        while (!rsp_valid && s < 20) begin
            if (stall) s++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(s == 4 && rsp_valid && rsp_rdata == seed(8'h80), "R8 refill unaffected",
            rsp_rdata, seed(8'h80));
        @(negedge clk);
        if (rsp_valid) extra++;
        chk(extra == 0, "R8 no response for stalled request", 32'(extra), 0);
        begin
            logic h; logic [31:0] q; int s2;
            issue(1'b0, 8'h90, 0, h, q, s2);
            chk(h == 1'b0 && q == seed(8'h90), "R8 stalled store dropped", q, seed(8'h90));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_miss_then_hit();
        t_store_hit();
        t_bypass();
        t_order();
        t_nonmatch();
        t_store_miss();
        t_conflict();
        t_ignore();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule